// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block arbitrates up to 32 level-sensitive interrupt request lines for a CPU core. Each source has a 4-bit priority level. Most sources take their level from a 4-bit field of one of three 16-bit priority registers, written over a small register bus. The other sources use a fixed level set at elaboration. The block also holds the CPU status word. Its mask level and its block bit decide which requests may interrupt.

At each instruction boundary, which the core marks with a strobe, the highest-level eligible request is taken. The block then does four things:
- saves the old status, the current PC and general register 15 into shadow registers;
- sets the block, privileged-mode and register-bank bits in the status word;
- loads the winner's event code;
- presents the handler address, which is the vector base plus 0x600.

A single-cycle accept pulse tells the core to jump to that address.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset the status word reads 0x700000F0, all priority registers are zero, accept_o is low, and the event code, vector and shadow outputs are zero.
- R2: A source's level comes from a selected register and nibble. The selector encoding is 0 for fixed, 1 for priority register 0, 2 for register 1 and 3 for register 2. The nibble index n picks bits [4n+3:4n]. With the default configuration, sources 0, 1 and 2 use register 0 nibbles 3, 2 and 1. Sources 3 and 4 use register 1 nibbles 3 and 2. Source 5 uses register 2 nibble 0. Sources 6 and 7 have a fixed level of 10.
- R3: While status bit 28 (block) is set, no request is accepted, whatever its level.
- R4: A request is eligible only if its level is strictly greater than the mask level in status bits [7:4].
- R5: Among eligible requests, the one with the highest level wins.
- R6: When eligible requests share the top level, the lowest source index wins.
- R7: On acceptance, ssr_o takes the old status word, spc_o takes pc_i and sgr_o takes r15_i.
- R8: On acceptance, status bits 28, 29 and 30 are set and all other status bits are kept.
- R9: On acceptance, vector_o becomes vbr_i + 0x600 and evt_code_o becomes the winner's code. The default code is 0x400 + 0x20 * index.
- R10: Acceptance happens only in a cycle with boundary_i high. accept_o pulses for exactly one cycle, in the cycle after that boundary.
- R11: Requests are level-sensitive. A request that is held is re-arbitrated at each boundary. A priority register write affects the next boundary and needs no re-assertion of the request.
- R12: Register bus addresses 0 to 2 write priority registers 0 to 2. Only bits [15:0] are kept. Address 3 writes the full status word. If a status write falls in the same cycle as an acceptance, the acceptance wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | N_SRC | Level-sensitive request lines |
| boundary_i | input | 1 | Instruction boundary strobe |
| pc_i | input | 32 | Current PC from the core |
| r15_i | input | 32 | Current general register 15 |
| vbr_i | input | 32 | Vector base register |
| reg_we_i | input | 1 | Register bus write enable |
| reg_addr_i | input | 2 | Register bus address |
| reg_wdata_i | input | 32 | Register bus write data |
| accept_o | output | 1 | One-cycle acceptance pulse |
| evt_code_o | output | EVT_W | Event code of the last accepted source |
| vector_o | output | 32 | Handler address |
| sr_o | output | 32 | Status word |
| ssr_o | output | 32 | Saved status |
| spc_o | output | 32 | Saved PC |
| sgr_o | output | 32 | Saved register 15 |

## Verification
The arbitration is tried with several request patterns, and each pattern separates one ordering rule.
- A single fixed-level source checks the basic accept path.
- Two fixed sources at equal level show whether ties go to the lower index.
- A mix of register-programmed sources at distinct levels shows whether the true maximum wins, and whether each source reads its own register and nibble.
- Mask values equal to and one below a source's level separate the strict comparison from a greater-or-equal one.
- Rewriting priority registers while requests are held shows that the winner changes with no re-request.
- Writes with nonzero upper bits, and a status write that collides with an acceptance, cover the bus corner cases.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int MAX_SRC  = 32;
  localparam int LVL_W    = 4;
  localparam int PREG_W   = 16;
  localparam int NUM_PREG = 3;
  localparam int EVT_W    = 12;
  localparam int SR_BL    = 28;
  localparam int SR_RB    = 29;
  localparam int SR_MD    = 30;
  localparam logic [31:0] SR_RESET = 32'h7000_00F0;
  localparam logic [31:0] SR_TAKE  = 32'h7000_0000;
  localparam logic [31:0] VEC_OFS  = 32'h0000_0600;
  localparam logic [1:0]  ADDR_SR  = 2'd3;

  typedef logic [LVL_W-1:0] lvl_t;

  function automatic logic [MAX_SRC*EVT_W-1:0] default_codes();
    logic [MAX_SRC*EVT_W-1:0] c;
    c = '0;
    for (int i = 0; i < MAX_SRC; i++) c[i*EVT_W +: EVT_W] = 12'h400 + 12'(i * 32);
    return c;
  endfunction
endpackage

// File: rtl/irq_prio_regs.sv
module irq_prio_regs
  import irq_pkg::*;
(
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic [1:0]                 addr_i,
  input  logic [PREG_W-1:0]          wdata_i,
  output logic [NUM_PREG*PREG_W-1:0] preg_o
);
  for (genvar g = 0; g < NUM_PREG; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) preg_o[g*PREG_W +: PREG_W] <= '0;
      else if (we_i && addr_i == 2'(g)) preg_o[g*PREG_W +: PREG_W] <= wdata_i;
    end
  end
endmodule

// File: rtl/irq_level_map.sv
module irq_level_map
  import irq_pkg::*;
#(
  parameter int                       N_SRC = 8,
  parameter logic [2*MAX_SRC-1:0]     SEL   = '0,
  parameter logic [2*MAX_SRC-1:0]     NIB   = '0,
  parameter logic [LVL_W*MAX_SRC-1:0] FIXED = '0
) (
  input  logic [NUM_PREG*PREG_W-1:0] preg_i,
  output logic [N_SRC*LVL_W-1:0]     lvl_o
);
  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    localparam int S = int'(SEL[2*g +: 2]);
    localparam int K = int'(NIB[2*g +: 2]);
    if (S == 0) begin : g_fixed
      assign lvl_o[g*LVL_W +: LVL_W] = FIXED[g*LVL_W +: LVL_W];
    end else begin : g_field
      assign lvl_o[g*LVL_W +: LVL_W] = preg_i[(S-1)*PREG_W + K*LVL_W +: LVL_W];
    end
  end
endmodule

// File: rtl/irq_pick.sv
module irq_pick
  import irq_pkg::*;
#(
  parameter int N_SRC = 8,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0]       irq_i,
  input  logic [N_SRC*LVL_W-1:0] lvl_i,
  input  lvl_t                   mask_i,
  input  logic                   block_i,
  output logic                   valid_o,
  output logic [IDX_W-1:0]       idx_o,
  output lvl_t                   lvl_o
);
  // strict '>' on the running best keeps the lower index on ties
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    lvl_o   = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (irq_i[i] && !block_i && lvl_i[i*LVL_W +: LVL_W] > mask_i &&
          (!valid_o || lvl_i[i*LVL_W +: LVL_W] > lvl_o)) begin
        valid_o = 1'b1;
        idx_o   = IDX_W'(i);
        lvl_o   = lvl_i[i*LVL_W +: LVL_W];
      end
    end
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_pkg::*;
#(
  parameter int                       N_SRC = 8,
  parameter logic [2*MAX_SRC-1:0]     SEL   = 64'h0E95,
  parameter logic [2*MAX_SRC-1:0]     NIB   = 64'h02DB,
  parameter logic [LVL_W*MAX_SRC-1:0] FIXED = 128'hAA00_0000,
  parameter logic [EVT_W*MAX_SRC-1:0] CODES = default_codes(),
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] irq_i,
  input  logic             boundary_i,
  input  logic [31:0]      pc_i,
  input  logic [31:0]      r15_i,
  input  logic [31:0]      vbr_i,
  input  logic             reg_we_i,
  input  logic [1:0]       reg_addr_i,
  input  logic [31:0]      reg_wdata_i,
  output logic             accept_o,
  output logic [EVT_W-1:0] evt_code_o,
  output logic [31:0]      vector_o,
  output logic [31:0]      sr_o,
  output logic [31:0]      ssr_o,
  output logic [31:0]      spc_o,
  output logic [31:0]      sgr_o
);
  logic [NUM_PREG*PREG_W-1:0] preg;
  logic [N_SRC*LVL_W-1:0]     lvl;
  logic                       win_valid;
  logic [IDX_W-1:0]           win_idx;
  lvl_t                       win_lvl;
  logic [31:0]                sr_q;
  logic                       take;

  irq_prio_regs u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (reg_we_i && reg_addr_i != ADDR_SR),
    .addr_i (reg_addr_i),
    .wdata_i(reg_wdata_i[PREG_W-1:0]),
    .preg_o (preg)
  );

  irq_level_map #(.N_SRC(N_SRC), .SEL(SEL), .NIB(NIB), .FIXED(FIXED)) u_map (
    .preg_i(preg),
    .lvl_o (lvl)
  );

  irq_pick #(.N_SRC(N_SRC)) u_pick (
    .irq_i  (irq_i),
    .lvl_i  (lvl),
    .mask_i (sr_q[7:4]),
    .block_i(sr_q[SR_BL]),
    .valid_o(win_valid),
    .idx_o  (win_idx),
    .lvl_o  (win_lvl)
  );

  assign take = boundary_i && win_valid;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q       <= SR_RESET;
      accept_o   <= 1'b0;
      evt_code_o <= '0;
      vector_o   <= '0;
      ssr_o      <= '0;
      spc_o      <= '0;
      sgr_o      <= '0;
    end else begin
      accept_o <= take;
      if (take) begin
        ssr_o      <= sr_q;
        spc_o      <= pc_i;
        sgr_o      <= r15_i;
        evt_code_o <= CODES[win_idx*EVT_W +: EVT_W];
        vector_o   <= vbr_i + VEC_OFS;
        sr_q       <= sr_q | SR_TAKE;
      end else if (reg_we_i && reg_addr_i == ADDR_SR) begin
        sr_q <= reg_wdata_i;
      end
    end
  end

  assign sr_o = sr_q;

  a_r3_block_mutes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (boundary_i && sr_q[SR_BL]) |=> !accept_o);
  a_r4_strict_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_valid |-> (irq_i[win_idx] && win_lvl > sr_q[7:4]));
  a_r7_shadow_save: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |-> (ssr_o == $past(sr_q) && spc_o == $past(pc_i) && sgr_o == $past(r15_i)));
  a_r8_status_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |-> (sr_q[SR_BL] && sr_q[SR_MD] && sr_q[SR_RB]));
  a_r9_vector: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |-> vector_o == $past(vbr_i) + VEC_OFS);
  a_r10_one_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |=> !accept_o);
  a_r10_after_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |-> $past(boundary_i));
endmodule

// File: tb/irq_prio_ctrl_test.sv
module irq_prio_ctrl_test;
  localparam int N = 8;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [N-1:0] irq_i = '0;
  logic        boundary_i = 1'b0;
  logic [31:0] pc_i = 32'h8C00_1000;
  logic [31:0] r15_i = 32'h8D00_FF00;
  logic [31:0] vbr_i = 32'h8C00_0000;
  logic        reg_we_i = 1'b0;
  logic [1:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic        accept_o;
  logic [11:0] evt_code_o;
  logic [31:0] vector_o, sr_o, ssr_o, spc_o, sgr_o;

  irq_prio_ctrl uut (.*);

  always #4 clk_i = ~clk_i;

  typedef struct {
    bit          acc;
    logic [11:0] evt;
    logic [31:0] ssr, spc, sgr, vec, sr_after;
    string       tag;
  } item_t;

  item_t       q[$];
  int          total = 0;
  int          bad = 0;
  bit          run = 0;
  logic [31:0] sr_m = 32'h7000_00F0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
    if (a == 2'd3) sr_m = d;
  endtask

  // driver: one boundary strobe, optionally with a colliding status write
  task automatic bnd(input bit acc, input int src, input string tag,
                     input bit do_wr = 0, input logic [31:0] wd = '0);
    item_t it;
    @(negedge clk_i);
    boundary_i = 1'b1;
    if (do_wr) begin reg_we_i = 1'b1; reg_addr_i = 2'd3; reg_wdata_i = wd; end
    it.acc = acc;
    it.evt = 12'h400 + 12'(src * 32);
    it.ssr = sr_m; it.spc = pc_i; it.sgr = r15_i; it.vec = vbr_i + 32'h600;
    it.tag = tag;
    if (acc) sr_m = sr_m | 32'h7000_0000;
    else if (do_wr) sr_m = wd;
    it.sr_after = sr_m;
    q.push_back(it);
    @(negedge clk_i);
    boundary_i = 1'b0; reg_we_i = 1'b0;
    @(negedge clk_i);
  endtask

  // monitor: compares results one clock after each boundary
  always @(posedge clk_i) begin
    #2;
    if (run) begin
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        chk(accept_o == it.acc, {it.tag, " accept"}, 32'(accept_o), 32'(it.acc));
        if (it.acc) begin
          chk(evt_code_o == it.evt, {it.tag, " evt"}, 32'(evt_code_o), 32'(it.evt));
          chk(vector_o == it.vec, {it.tag, " vector"}, vector_o, it.vec);
          chk(ssr_o == it.ssr, {it.tag, " ssr"}, ssr_o, it.ssr);
          chk(spc_o == it.spc, {it.tag, " spc"}, spc_o, it.spc);
          chk(sgr_o == it.sgr, {it.tag, " sgr"}, sgr_o, it.sgr);
        end
        chk(sr_o == it.sr_after, {it.tag, " sr"}, sr_o, it.sr_after);
      end else if (accept_o) begin
        chk(1'b0, "R10 stray accept", 32'(accept_o), 32'd0);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    chk(1'b0, "watchdog", 32'd0, 32'd1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk(sr_o == 32'h7000_00F0, "R1 sr", sr_o, 32'h7000_00F0);
    chk(accept_o == 1'b0, "R1 accept", 32'(accept_o), 32'd0);
    chk(ssr_o == 0 && spc_o == 0 && sgr_o == 0, "R1 shadow", ssr_o, 32'd0);
    chk(evt_code_o == 0 && vector_o == 0, "R1 evt/vector", vector_o, 32'd0);
    run = 1;

    // R1/R3: blocked after reset; R3: block bit with mask 0
    irq_i = 8'h40;
    bnd(0, 6, "R1 R3 blocked at reset");
    wr(2'd3, 32'h1000_0000);
    bnd(0, 6, "R3 block bit mask0");

    // R7 R8 R9 R10 basic accept of fixed source 6
    wr(2'd3, 32'h0000_0000);
    bnd(1, 6, "R7 R8 R9 R10 src6");

    // R6 tie between fixed sources 6 and 7
    irq_i = 8'hC0;
    wr(2'd3, 32'h0000_0005);
    bnd(1, 6, "R6 tie src6 over src7");
    irq_i = 8'h80;
    wr(2'd3, 32'h0000_0000);
    bnd(1, 7, "R11 src7 still held");

    // R4 strict comparison against mask
    wr(2'd3, 32'h0000_00A0);
    bnd(0, 7, "R4 level equal to mask");
    wr(2'd3, 32'h0000_0090);
    bnd(1, 7, "R4 level above mask");

    // R2 R5 register-programmed levels
    wr(2'd0, 32'h0000_5300);
    wr(2'd1, 32'h0000_C000);
    wr(2'd2, 32'h0000_0007);
    irq_i = 8'b0010_1011;
    wr(2'd3, 32'h0000_0000);
    bnd(1, 3, "R5 R2 src3 level12");
    irq_i = 8'b0010_0011;
    wr(2'd3, 32'h0000_0000);
    bnd(1, 5, "R2 R5 src5 reg2 nibble0");

    // R11 reprogram while requests held
    wr(2'd2, 32'h0000_0000);
    wr(2'd3, 32'h0000_0000);
    bnd(1, 0, "R11 src5 dropped to 0");
    wr(2'd0, 32'h0000_5500);
    wr(2'd3, 32'h0000_0000);
    bnd(1, 0, "R6 R11 src0 ties src1");
    wr(2'd0, 32'h0000_3500);
    wr(2'd3, 32'h0000_0000);
    bnd(1, 1, "R11 src1 raised");

    // R2 nibble 1 of register 0
    wr(2'd0, 32'h0000_00F0);
    irq_i = 8'h04;
    wr(2'd3, 32'h0000_00E0);
    bnd(1, 2, "R2 src2 nibble1");

    // R12 upper bits dropped on priority write
    wr(2'd0, 32'hFFFF_0000);
    irq_i = 8'h07;
    wr(2'd3, 32'h0000_0000);
    bnd(0, 0, "R12 upper bits ignored");

    // R10 no boundary, no accept
    irq_i = 8'h40;
    wr(2'd3, 32'h0000_0000);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk_i);
      chk(accept_o == 1'b0, "R10 no boundary", 32'(accept_o), 32'd0);
    end

    // R12 status write collides with acceptance
    bnd(1, 6, "R12 accept beats status write", 1, 32'h1234_5678);
    wr(2'd3, 32'h0000_00C3);
    irq_i = 8'h00;
    bnd(0, 0, "R12 status full write", 1, 32'h0000_00C3);

    repeat (3) @(negedge clk_i);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule